// File: doc/BRIEF.md
# Grayscale Framebuffer Magnifying Scan-Out

This block turns a packed 4-bit grayscale frame memory into a stream of colour pixels for a display surface. The memory holds two pixels per byte. The block reads it through a synchronous RAM read port that returns data one cycle after the request. Each source pixel becomes a square of MAG x MAG output pixels. With the default sizes, 64 bytes per row (128 pixels) over 64 visible rows give a 512 x 256 output frame.

Each gray level is widened to the component width of the selected output format: 15-bit RGB, 16-bit RGB, or 24-bit gray. The pixel stream uses a valid/ready handshake. It also carries a start-of-frame marker and an end-of-line marker.

Scan-out is driven by a redraw request. Any write to the frame memory is signalled on a strobe, and that strobe raises the request. While the request is set, one full frame is streamed. The request is then dropped, unless another write arrived during that frame. To repeat each line vertically, the block reads the same source row again for every repeat, so it needs no line buffer.

Top module: `gray_scanout`

## Requirements
- R1: While reset is held and in the cycle after it is released, `px_valid`, `ram_rd_en` and `redraw_req` are all 0.
- R2: `redraw_req` is 1 in the cycle after `wr_strobe` is sampled high. While `redraw_req` is 0, no pixel is offered (`px_valid` stays 0).
- R3: A frame has OUT_W x OUT_H pixels, where OUT_W = COL_BYTES*2*MAG and OUT_H = ROWS*MAG. Pixels come in raster order. Source row r, byte c is read from address r*ROW_STRIDE + c. Rows at or beyond ROWS are never shown.
- R4: Within a byte, bits 7:4 hold the left pixel and bits 3:0 hold the right pixel.
- R5: Each source pixel is repeated MAG times along the line, and each source line is output MAG times.
- R6: With `fmt_sel` = 0 (15-bit), the 5-bit level is n = 2*i + (i>>3) for a gray level i. Fields [14:10], [9:5] and [4:0] all equal n, and bits [23:15] are 0.
- R7: With `fmt_sel` = 1 (16-bit), [15:11] = n, [10:5] = {n, n[4]}, [4:0] = n, and bits [23:16] are 0.
- R8: With `fmt_sel` = 2 or 3 (24-bit gray), each of the three bytes [23:16], [15:8] and [7:0] equals {i, i}.
- R9: `px_sof` is 1 on the first pixel of a frame only. `px_eol` is 1 on the last pixel of every output line and on no other pixel.
- R10: While `px_valid` is 1 and `px_ready` is 0, `px_data`, `px_sof` and `px_eol` hold their values and `px_valid` stays 1.
- R11: `redraw_req` falls in the cycle after the last pixel of a frame is accepted. If `wr_strobe` was high at any time during that frame, the request stays set and a further frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | Pulse for every write into the frame memory |
| fmt_sel | input | 2 | Output format: 0 = 15-bit RGB, 1 = 16-bit RGB, 2/3 = 24-bit gray |
| ram_rd_en | output | 1 | Read request to the frame memory |
| ram_rd_addr | output | ADDR_W | Byte address of the read request |
| ram_rd_data | input | 8 | Read data, valid one cycle after `ram_rd_en` |
| px_valid | output | 1 | Pixel on `px_data` is valid |
| px_ready | input | 1 | Sink accepts the pixel |
| px_data | output | 24 | Pixel in the selected format, right-aligned |
| px_sof | output | 1 | Marks the first pixel of a frame |
| px_eol | output | 1 | Marks the last pixel of an output line |
| redraw_req | output | 1 | A frame is pending or being streamed |

## Verification
The frame memory is filled so that every one of the 16 gray levels appears, including 7 and 8, where the top bit carries into n[0] and into the low bit of the 6-bit green. A design with a wrong widening rule would show wrong values exactly there. Rows past the visible count, and the padding bytes past each row's width, hold distinct data, so a wrong stride or a wrong row count would leak them into the stream.

Frames run both with ready held high and with random stalls. A design that lets data change during a stall, that swaps nibbles, or that miscounts the horizontal or vertical repeats fails the per-pixel compare or the marker compare.

A write strobe fired in the middle of a frame must leave the request set, so a second frame must follow. A design that clears the request unconditionally at the end of a frame would stop after one frame.

// File: rtl/gs_pkg.sv
package gs_pkg;

  typedef enum logic [1:0] {
    FMT_RGB15  = 2'd0,
    FMT_RGB16  = 2'd1,
    FMT_GRAY24 = 2'd2,
    FMT_GRAY24_ALT = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_CAP   = 3'd2,
    ST_EMIT  = 3'd3,
    ST_FLUSH = 3'd4
  } scan_st_e;

  localparam int PIX_W = 24;

endpackage

// File: rtl/gs_pix_expand.sv
module gs_pix_expand
  import gs_pkg::*;
(
  input  logic [3:0]       level,
  input  fmt_e             fmt,
  output logic [PIX_W-1:0] pix
);

  logic [4:0] n5;

  always_comb begin
    n5 = {level, level[3]};
    case (fmt)
      FMT_RGB15: pix = {9'd0, n5, n5, n5};
      FMT_RGB16: pix = {8'd0, n5, n5, n5[4], n5};
      default:   pix = {level, level, level, level, level, level};
    endcase
  end

endmodule

// File: rtl/gs_redraw_flag.sv
module gs_redraw_flag (
  input  logic clk,
  input  logic rst,
  input  logic wr_strobe,
  input  logic frame_start,
  input  logic frame_done,
  output logic pending
);

  logic again_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      again_q <= 1'b0;
    end else begin
      if (frame_start) begin
        again_q <= wr_strobe;
      end else if (frame_done) begin
        again_q <= 1'b0;
      end else if (wr_strobe) begin
        again_q <= 1'b1;
      end

      if (frame_done) begin
        pending <= again_q | wr_strobe;
      end else if (wr_strobe) begin
        pending <= 1'b1;
      end
    end
  end

  AST_REQ_SET: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> pending); // R2

endmodule

// File: rtl/gs_scan_ctrl.sv
module gs_scan_ctrl
  import gs_pkg::*;
#(
  parameter int COL_BYTES  = 64,
  parameter int ROWS       = 64,
  parameter int MAG        = 4,
  parameter int ROW_STRIDE = 64,
  parameter int ADDR_W     = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  fmt_e              fmt,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [7:0]        ram_rd_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [PIX_W-1:0]  px_data,
  output logic              px_sof,
  output logic              px_eol,
  output logic              frame_start,
  output logic              frame_done
);

  localparam int CB_W = (COL_BYTES > 1) ? $clog2(COL_BYTES) : 1;
  localparam int RW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int MG_W = (MAG > 1) ? $clog2(MAG) : 1;
  localparam int ADDR_LIMIT = (ROWS - 1) * ROW_STRIDE + COL_BYTES;

  scan_st_e          state;
  logic [CB_W-1:0]   col_q;
  logic [RW_W-1:0]   row_q;
  logic [MG_W-1:0]   rep_x_q;
  logic [MG_W-1:0]   rep_y_q;
  logic              half_q;
  logic [7:0]        byte_q;
  logic [3:0]        level;
  logic [PIX_W-1:0]  pix_next;
  logic              take;
  logic              last_col, last_row, last_rx, last_ry;
  logic              first_pix, line_end;

  assign last_col  = (col_q == CB_W'(COL_BYTES - 1));
  assign last_row  = (row_q == RW_W'(ROWS - 1));
  assign last_rx   = (rep_x_q == MG_W'(MAG - 1));
  assign last_ry   = (rep_y_q == MG_W'(MAG - 1));
  assign first_pix = (col_q == '0) && !half_q && (rep_x_q == '0) &&
                     (rep_y_q == '0) && (row_q == '0);
  assign line_end  = last_col && half_q && last_rx;
  assign take      = !px_valid || px_ready;

  assign level = half_q ? byte_q[3:0] : byte_q[7:4];

  gs_pix_expand u_expand (
    .level (level),
    .fmt   (fmt),
    .pix   (pix_next)
  );

  assign ram_rd_en   = (state == ST_REQ);
  assign ram_rd_addr = ADDR_W'(int'(row_q) * ROW_STRIDE + int'(col_q));
  assign frame_start = (state == ST_IDLE) && go;
  assign frame_done  = (state == ST_FLUSH) && px_valid && px_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      col_q    <= '0;
      row_q    <= '0;
      rep_x_q  <= '0;
      rep_y_q  <= '0;
      half_q   <= 1'b0;
      byte_q   <= '0;
      px_valid <= 1'b0;
      px_data  <= '0;
      px_sof   <= 1'b0;
      px_eol   <= 1'b0;
    end else begin
      if (px_valid && px_ready) px_valid <= 1'b0;
      case (state)
        ST_IDLE: if (go) state <= ST_REQ;
        ST_REQ:  state <= ST_CAP;
        ST_CAP: begin
          byte_q <= ram_rd_data;
          state  <= ST_EMIT;
        end
        ST_EMIT: if (take) begin
          px_valid <= 1'b1;
          px_data  <= pix_next;
          px_sof   <= first_pix;
          px_eol   <= line_end;
          if (!last_rx) begin
            rep_x_q <= rep_x_q + 1'b1;
          end else begin
            rep_x_q <= '0;
            if (!half_q) begin
              half_q <= 1'b1;
            end else begin
              half_q <= 1'b0;
              if (!last_col) begin
                col_q <= col_q + 1'b1;
                state <= ST_REQ;
              end else begin
                col_q <= '0;
                if (!last_ry) begin
                  rep_y_q <= rep_y_q + 1'b1;
                  state   <= ST_REQ;
                end else begin
                  rep_y_q <= '0;
                  if (!last_row) begin
                    row_q <= row_q + 1'b1;
                    state <= ST_REQ;
                  end else begin
                    row_q <= '0;
                    state <= ST_FLUSH;
                  end
                end
              end
            end
          end
        end
        ST_FLUSH: if (px_valid && px_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_data) &&
                                 $stable(px_sof) && $stable(px_eol))); // R10

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> (int'(ram_rd_addr) < ADDR_LIMIT)); // R3

  AST_SOF_ALONE: assert property (@(posedge clk) disable iff (rst)
    (px_valid && px_sof) |-> (int'(row_q) + int'(col_q) + int'(rep_y_q) == 0)); // R9

endmodule

// File: rtl/gray_scanout.sv
module gray_scanout
  import gs_pkg::*;
#(
  parameter int COL_BYTES  = 64,
  parameter int ROWS       = 64,
  parameter int MAG        = 4,
  parameter int ROW_STRIDE = 64,
  parameter int RAM_ROWS   = 80,
  localparam int ADDR_W    = $clog2(ROW_STRIDE * RAM_ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_strobe,
  input  logic [1:0]        fmt_sel,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [7:0]        ram_rd_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [23:0]       px_data,
  output logic              px_sof,
  output logic              px_eol,
  output logic              redraw_req
);

  logic frame_start;
  logic frame_done;

  gs_redraw_flag u_flag (
    .clk         (clk),
    .rst         (rst),
    .wr_strobe   (wr_strobe),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .pending     (redraw_req)
  );

  gs_scan_ctrl #(
    .COL_BYTES  (COL_BYTES),
    .ROWS       (ROWS),
    .MAG        (MAG),
    .ROW_STRIDE (ROW_STRIDE),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .go          (redraw_req),
    .fmt         (fmt_e'(fmt_sel)),
    .ram_rd_en   (ram_rd_en),
    .ram_rd_addr (ram_rd_addr),
    .ram_rd_data (ram_rd_data),
    .px_valid    (px_valid),
    .px_ready    (px_ready),
    .px_data     (px_data),
    .px_sof      (px_sof),
    .px_eol      (px_eol),
    .frame_start (frame_start),
    .frame_done  (frame_done)
  );

  AST_NO_STREAM_IDLE: assert property (@(posedge clk) disable iff (rst)
    !redraw_req |-> !px_valid); // R2

endmodule

// File: tb/gray_scanout_tb.sv
module gray_scanout_tb;

  localparam int CB = 4;
  localparam int RW = 3;
  localparam int MG = 4;
  localparam int ST = 8;
  localparam int RR = 5;
  localparam int OW = CB * 2 * MG;
  localparam int OH = RW * MG;
  localparam int FP = OW * OH;
  localparam int DEPTH = ST * RR;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_strobe = 1'b0;
  logic [1:0]    fmt_sel = 2'd0;
  logic          ram_rd_en;
  logic [AW-1:0] ram_rd_addr;
  logic [7:0]    ram_rd_data = 8'd0;
  logic          px_valid;
  logic          px_ready = 1'b0;
  logic [23:0]   px_data;
  logic          px_sof, px_eol, redraw_req;

  always #2 clk = ~clk;

  gray_scanout #(
    .COL_BYTES(CB), .ROWS(RW), .MAG(MG), .ROW_STRIDE(ST), .RAM_ROWS(RR)
  ) u_dut (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .fmt_sel(fmt_sel),
    .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data),
    .px_sof(px_sof), .px_eol(px_eol), .redraw_req(redraw_req)
  );

  logic [7:0] mem [DEPTH];

  always @(posedge clk) if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];

  int n_chk = 0;
  int n_fail = 0;
  int pix_k = 0;
  int frames = 0;
  bit stall_mode = 1'b0;
  bit held_q = 1'b0;
  logic [25:0] held_val;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_pix(input int k, input logic [1:0] f);
    int y, x, r, c, h, i, n, g;
    logic [7:0] b;
    y = k / OW;
    x = k % OW;
    r = y / MG;
    c = x / (2 * MG);
    h = (x / MG) % 2;
    b = mem[r * ST + c];
    i = (h == 1) ? int'(b[3:0]) : int'(b[7:4]);
    n = 2 * i + (i >> 3);
    g = (n << 1) | (n >> 4);
    case (f)
      2'd0: exp_pix = 24'((n << 10) | (n << 5) | n);
      2'd1: exp_pix = 24'((n << 11) | (g << 5) | n);
      default: exp_pix = 24'((i * 17) << 16 | (i * 17) << 8 | (i * 17));
    endcase
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    case (f)
      2'd0: fmt_tag = "R3 R4 R5 R6 data";
      2'd1: fmt_tag = "R3 R4 R5 R7 data";
      default: fmt_tag = "R3 R4 R5 R8 data";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      px_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      if (held_q) begin
        check(px_valid && ({px_sof, px_eol, px_data} == held_val),
              "R10 hold", {5'd0, px_valid, px_sof, px_eol, px_data},
              {6'd1, held_val});
      end
      if (px_valid && px_ready) begin
        logic [23:0] e;
        bit es, ee;
        e  = exp_pix(pix_k, fmt_sel);
        es = (pix_k == 0);
        ee = ((pix_k % OW) == OW - 1);
        check(px_data == e, fmt_tag(fmt_sel), {8'd0, px_data}, {8'd0, e});
        check((px_sof == es) && (px_eol == ee), "R9 markers",
              {30'd0, px_sof, px_eol}, {30'd0, es, ee});
        pix_k++;
        if (pix_k == FP) begin
          pix_k = 0;
          frames++;
        end
      end
      held_q   = px_valid && !px_ready;
      held_val = {px_sof, px_eol, px_data};
    end
  end

  task automatic strobe(input int a, input logic [7:0] v, input bit change);
    @(negedge clk);
    if (change) mem[a] = v;
    wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    int t = 0;
    while (frames < target && t < 20000) begin
      @(posedge clk);
      t++;
    end
    check(frames >= target, "R3 frame complete", 32'(frames), 32'(target));
  endtask

  task automatic one_frame(input logic [1:0] f, input bit stall, input string tag);
    int base;
    base = frames;
    fmt_sel = f;
    stall_mode = stall;
    strobe(0, mem[0], 1'b0);
    check(redraw_req == 1'b1, "R2 request raised", 32'(redraw_req), 32'd1);
    wait_frames(base + 1);
    @(negedge clk);
    check(redraw_req == 1'b0, {"R11 request cleared ", tag}, 32'(redraw_req), 32'd0);
    repeat (8) @(negedge clk);
    check(px_valid == 1'b0 && pix_k == 0, "R3 R2 no extra pixels",
          {31'd0, px_valid}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1234_5678));
    for (int a = 0; a < DEPTH; a++) mem[a] = 8'($urandom);
    // every gray level appears in rows 0 and 1
    for (int c = 0; c < CB; c++) begin
      mem[c]      = 8'(((2 * c) << 4) | (2 * c + 1));
      mem[ST + c] = 8'(((2 * c + 8) << 4) | (2 * c + 9));
    end
    repeat (4) @(negedge clk);
    check(px_valid == 0 && ram_rd_en == 0 && redraw_req == 0, "R1 in reset",
          {29'd0, px_valid, ram_rd_en, redraw_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(px_valid == 0 && ram_rd_en == 0 && redraw_req == 0, "R1 after reset",
          {29'd0, px_valid, ram_rd_en, redraw_req}, 32'd0);
    repeat (20) @(negedge clk);
    check(px_valid == 0 && redraw_req == 0 && frames == 0 && pix_k == 0,
          "R2 idle without write", {31'd0, px_valid}, 32'd0);

    one_frame(2'd0, 1'b0, "fmt0");
    one_frame(2'd1, 1'b1, "fmt1");
    for (int a = 0; a < DEPTH; a++) mem[a] = 8'($urandom);
    one_frame(2'd2, 1'b1, "fmt2");
    mem[0] = 8'h78;
    mem[1] = 8'hF0;
    one_frame(2'd3, 1'b0, "fmt3");

    // write during a frame keeps the request alive for one more frame
    begin
      int base;
      base = frames;
      fmt_sel = 2'd1;
      stall_mode = 1'b1;
      strobe(0, mem[0], 1'b0);
      while (pix_k < FP / 2) @(posedge clk);
      strobe(0, mem[0], 1'b0);
      wait_frames(base + 1);
      @(negedge clk);
      check(redraw_req == 1'b1, "R11 rearmed after mid-frame write",
            32'(redraw_req), 32'd1);
      wait_frames(base + 2);
      @(negedge clk);
      check(redraw_req == 1'b0, "R11 cleared after second frame",
            32'(redraw_req), 32'd0);
    end

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule